// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry input. It returns the 16-bit sum, the carry out of the most significant bit, and a flag for two's-complement overflow. No carry ripples from bit to bit.

The operand width is split into 4-bit slices. Each slice forms a generate term (both operand bits set) and a propagate term (operand bits differ) for every bit. From these it builds each internal carry as one flattened sum of products over the generate terms, the propagate terms and the slice's carry input. Each slice also reports one generate and one propagate signal for the whole slice.

A second lookahead network uses the same flattened equations on the four slice-level pairs. It produces the carry into slices 1, 2 and 3 and the final carry out. Both levels are built from one parameterised carry network. The slice width and the slice count are parameters.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, taking the operands as unsigned numbers.
- R2: `carry_out` equals bit 16 of the unsigned sum `a_in + b_in + carry_in`.
- R3: `ovf_out` is 1 exactly when `a_in[15]` equals `b_in[15]` and `sum_out[15]` differs from them. This is the same as the carry into bit 15 differing from the carry out of bit 15.
- R4: Raising `carry_in` from 0 to 1, with the operands held, raises the 17-bit result `{carry_out, sum_out}` by exactly one.
- R5: A carry that starts at bit 0 and propagates through all 16 bits reaches the output. 0xFFFF plus 0x0001 gives sum 0x0000, `carry_out` 1 and `ovf_out` 0. 0xFFFF plus 0x0000 with `carry_in` 1 gives the same result.
- R6: Inside every slice, the pattern 0xF plus 0x1 carries correctly into the next slice up. With 0x000F shifted left by 4*k plus 0x0001 shifted left by 4*k, for k = 0 to 3, the sum is 0x0010 shifted left by 4*k; at k = 3 this is 0x0000 with `carry_out` 1. 0xFFFF plus 0x1111 gives 0x1110 with `carry_out` 1.
- R7: Positive overflow: 0x7FFF plus 0x0001 gives sum 0x8000, `carry_out` 0 and `ovf_out` 1.
- R8: Negative overflow: 0x8000 plus 0x8000 gives sum 0x0000, `carry_out` 1 and `ovf_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf_out | output | 1 | Two's-complement overflow flag |

## Verification
The bench targets carry chains that must cross slice boundaries:
- **0xF plus 0x1 in one slice.** A design whose group generate or group propagate term was wrong, or whose slice-level network picked the wrong pair, would leave the next slice's low bit unchanged.
- **All ones plus one.** A missing product term in the flattened equations would drop the carry partway through the word, so the sum would not be zero.
- **The two overflow patterns (0x7FFF plus 1, 0x8000 plus 0x8000).** An overflow flag taken from the wrong carry pair would stay low on the positive case or mark ordinary unsigned carries as overflow.
- **The carry input alone.** A design that dropped the carry input from the all-propagate product terms would show no change when the carry input toggles.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int DEF_SLICE_W    = 4;
    localparam int DEF_NUM_SLICES = 4;

    // generate/propagate pair reported by one slice
    typedef struct packed {
        logic gen;
        logic prop;
    } grp_gp_t;

    // signed overflow from sign bits of the operands and the result
    function automatic logic sign_overflow(input logic a_msb,
                                           input logic b_msb,
                                           input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    logic term_v;
    logic sop_v;

    // each carry written as a flat OR of AND terms; no reuse of lower carries
    always_comb begin
        carry_o    = '0;
        carry_o[0] = cin_i;
        for (int k = 1; k <= N; k++) begin
            sop_v = 1'b0;
            for (int j = 0; j < k; j++) begin
                term_v = gen_i[j];
                for (int m = j + 1; m < k; m++) term_v = term_v & prop_i[m];
                sop_v = sop_v | term_v;
            end
            term_v = cin_i;
            for (int m = 0; m < k; m++) term_v = term_v & prop_i[m];
            carry_o[k] = sop_v | term_v;
        end
    end

    logic gsop_v;
    logic gterm_v;

    always_comb begin
        gsop_v = 1'b0;
        for (int j = 0; j < N; j++) begin
            gterm_v = gen_i[j];
            for (int m = j + 1; m < N; m++) gterm_v = gterm_v & prop_i[m];
            gsop_v = gsop_v | gterm_v;
        end
        grp_gen_o  = gsop_v;
        grp_prop_o = &prop_i;
    end

    // flattened carries must agree with the one-step recurrence
    always_comb begin
        for (int k = 1; k <= N; k++) begin
            // R5
            ripple_equiv_chk: assert (carry_o[k] == (gen_i[k-1] | (prop_i[k-1] & carry_o[k-1])))
                else $error("carry %0d disagrees with recurrence", k);
        end
        // R2
        group_out_chk: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & cin_i)))
            else $error("group pair disagrees with top carry");
    end

endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         msb_cin_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    logic [W-1:0] bit_gen_d;
    logic [W-1:0] bit_prop_d;
    logic [W:0]   carry_d;

    always_comb begin
        bit_gen_d  = a_i & b_i;
        bit_prop_d = a_i ^ b_i;
    end

    cla_carry_net #(.N(W)) u_net (
        .gen_i      (bit_gen_d),
        .prop_i     (bit_prop_d),
        .cin_i      (cin_i),
        .carry_o    (carry_d),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    always_comb begin
        sum_o     = bit_prop_d ^ carry_d[W-1:0];
        cout_o    = carry_d[W];
        msb_cin_o = carry_d[W-1];
    end

    always_comb begin
        // R1
        slice_sum_chk: assert ({cout_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
            else $error("slice sum mismatch");
    end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
    import cla_pkg::*;
#(
    parameter int SLICE_W    = DEF_SLICE_W,
    parameter int NUM_SLICES = DEF_NUM_SLICES,
    localparam int WIDTH     = SLICE_W * NUM_SLICES
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             ovf;
    } add_res_t;

    grp_gp_t [NUM_SLICES-1:0] grp_d;
    logic    [NUM_SLICES-1:0] grp_gen_d;
    logic    [NUM_SLICES-1:0] grp_prop_d;
    logic    [NUM_SLICES-1:0] slice_cout_d;
    logic    [NUM_SLICES-1:0] slice_msb_cin_d;
    logic    [NUM_SLICES:0]   grp_carry_d;
    logic    [WIDTH-1:0]      sum_d;
    logic                     top_gen_d;
    logic                     top_prop_d;
    add_res_t                 res_d;

    // second-level lookahead over the slice pairs
    cla_carry_net #(.N(NUM_SLICES)) u_lcu (
        .gen_i      (grp_gen_d),
        .prop_i     (grp_prop_d),
        .cin_i      (carry_in),
        .carry_o    (grp_carry_d),
        .grp_gen_o  (top_gen_d),
        .grp_prop_o (top_prop_d)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a_i        (a_in[s*SLICE_W +: SLICE_W]),
            .b_i        (b_in[s*SLICE_W +: SLICE_W]),
            .cin_i      (grp_carry_d[s]),
            .sum_o      (sum_d[s*SLICE_W +: SLICE_W]),
            .cout_o     (slice_cout_d[s]),
            .msb_cin_o  (slice_msb_cin_d[s]),
            .grp_gen_o  (grp_d[s].gen),
            .grp_prop_o (grp_d[s].prop)
        );
        assign grp_gen_d[s]  = grp_d[s].gen;
        assign grp_prop_d[s] = grp_d[s].prop;
    end

    always_comb begin
        res_d      = '0;
        res_d.sum  = sum_d;
        res_d.cout = grp_carry_d[NUM_SLICES];
        res_d.ovf  = slice_msb_cin_d[NUM_SLICES-1] ^ grp_carry_d[NUM_SLICES];
    end

    assign sum_out   = res_d.sum;
    assign carry_out = res_d.cout;
    assign ovf_out   = res_d.ovf;

    always_comb begin
        for (int s = 0; s < NUM_SLICES; s++) begin
            // R6
            slice_carry_chk: assert (slice_cout_d[s] == grp_carry_d[s+1])
                else $error("slice %0d carry disagrees with lookahead unit", s);
        end
        // R2
        top_carry_chk: assert (carry_out == (top_gen_d | (top_prop_d & carry_in)))
            else $error("final carry disagrees with top group pair");
        // R3
        ovf_rule_chk: assert (ovf_out == sign_overflow(a_in[WIDTH-1], b_in[WIDTH-1],
                                                       sum_out[WIDTH-1]))
            else $error("overflow flag disagrees with sign rule");
        // R1
        full_sum_chk: assert ({carry_out, sum_out} ==
                              ({1'b0, a_in} + {1'b0, b_in} + (WIDTH+1)'(carry_in)))
            else $error("full sum mismatch");
    end

endmodule

// File: tb/lookahead_adder_test.sv
module lookahead_adder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;
    logic        ovf_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lookahead_adder uut (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    function automatic logic [16:0] exp_total(input logic [15:0] a, input logic [15:0] b,
                                              input logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    function automatic logic exp_ovf(input logic [15:0] a, input logic [15:0] b,
                                     input logic [15:0] s);
        return (a[15] == b[15]) && (s[15] != a[15]);
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%05h expected 0x%05h", req, what, act, exp);
        end
    endtask

    // drive after a rising edge, sample at the following falling edge
    task automatic apply_and_check(input string req, input logic [15:0] a,
                                   input logic [15:0] b, input logic c);
        logic [16:0] tot;
        @(posedge clk);
        a_in = a; b_in = b; carry_in = c;
        @(negedge clk);
        tot = exp_total(a, b, c);
        check_val(req, "sum",   {1'b0, sum_out},   {1'b0, tot[15:0]});
        check_val(req, "carry", {16'd0, carry_out}, {16'd0, tot[16]});
        check_val(req, "ovf",   {16'd0, ovf_out},   {16'd0, exp_ovf(a, b, tot[15:0])});
    endtask

    task automatic expect_exact(input string req, input logic [15:0] a, input logic [15:0] b,
                                input logic c, input logic [15:0] s, input logic co,
                                input logic ov);
        @(posedge clk);
        a_in = a; b_in = b; carry_in = c;
        @(negedge clk);
        check_val(req, "sum",   {1'b0, sum_out},   {1'b0, s});
        check_val(req, "carry", {16'd0, carry_out}, {16'd0, co});
        check_val(req, "ovf",   {16'd0, ovf_out},   {16'd0, ov});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [16:0] lo_tot;
        logic [16:0] hi_tot;
        logic [15:0] ra;
        logic [15:0] rb;
        void'($urandom(32'h5EED_0C1A));

        // R1 R2 R3: all-zero operands
        @(negedge clk);
        check_val("R1", "idle sum",   {1'b0, sum_out},   17'd0);
        check_val("R2", "idle carry", {16'd0, carry_out}, 17'd0);
        check_val("R3", "idle ovf",   {16'd0, ovf_out},   17'd0);

        // R5: full-width propagate
        expect_exact("R5", 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0);
        expect_exact("R5", 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0);

        // R6: 0xF plus 0x1 inside every slice
        for (int k = 0; k < 4; k++) begin
            expect_exact("R6", 16'h000F << (4*k), 16'h0001 << (4*k), 1'b0,
                         16'h0010 << (4*k), (k == 3), 1'b0);
        end
        expect_exact("R6", 16'hFFFF, 16'h1111, 1'b0, 16'h1110, 1'b1, 1'b0);

        // R7, R8: overflow corners
        expect_exact("R7", 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1);
        expect_exact("R8", 16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1);
        expect_exact("R3", 16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b1, 1'b1);
        expect_exact("R3", 16'h4000, 16'hC000, 1'b0, 16'h0000, 1'b1, 1'b0);

        // R4: carry_in raises the result by one
        for (int n = 0; n < 40; n++) begin
            ra = 16'($urandom);
            rb = (n < 8) ? ~ra : 16'($urandom);
            @(posedge clk);
            a_in = ra; b_in = rb; carry_in = 1'b0;
            @(negedge clk);
            lo_tot = {carry_out, sum_out};
            @(posedge clk);
            carry_in = 1'b1;
            @(negedge clk);
            hi_tot = {carry_out, sum_out};
            check_val("R4", "carry_in step", hi_tot, lo_tot + 17'd1);
        end

        // R1 R2 R3: random operands, some biased toward long propagate runs
        for (int n = 0; n < 600; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 4 == 1) rb = ~ra ^ (16'h1 << ($urandom % 16));
            if (n % 4 == 2) begin
                ra = ra | 16'hF0F0;
                rb = (rb & 16'h0F0F) | 16'h1010;
            end
            apply_and_check("R1", ra, rb, 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule